// File: doc/BRIEF.md
# Start-Bit Framed Control-Byte Receiver

This block is the command input stage of a multi-channel data converter. It watches an active-low select line, a serial clock and a serial data line. While the select line is low it takes one data bit on each rising edge of the serial clock. Zero bits that arrive before the first one bit are thrown away. The first one bit marks the start of an 8-bit control word and becomes its most significant bit.

When the last of the seven bits after the marker has been taken in, the block decodes the word into a channel code, a polarity choice, an input-configuration choice and a two-bit power/clock mode. It holds these values in registers and raises a conversion request for exactly one system clock. The converter core behind it uses these held values.

All three serial inputs are resynchronised to the system clock. The serial clock's rising edge is detected from the resynchronised samples. After one word has been accepted, further bits are ignored until the select line has gone high and then low again.

Top module: `ctl_byte_rx`

## Requirements
- R1: After reset the outputs are: channel 0, unipolar 1, single-ended 1, power mode 00 (full power-down) and request low.
- R2: While select is low, any number of zero bits before the first one bit have no effect. The first one bit is bit 7 of the word, and the next seven bits fill bits 6 down to 0 in arrival order.
- R3: The fields are taken from fixed positions in the word. Channel is bits 6:4. Unipolar is bit 3 (1 = unipolar, 0 = bipolar). Single-ended is bit 2 (1 = single-ended, 0 = differential). Power mode is bits 1:0, coded 00 full power-down, 01 fast power-down, 10 internal clock, 11 external clock.
- R4: Each accepted word raises the request for exactly one system clock, and the new field values appear in that same cycle.
- R5: If select rises before the word is complete, the partial word is dropped. No request is raised, the fields keep their values, and a later select-low period can deliver a full word.
- R6: After a word is accepted, further serial bits within the same select-low period produce no request and change no field.
- R7: The field outputs change only in a cycle where the request is high.
- R8: A select-low period that carries only zero bits produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Active-low select, asynchronous |
| sclk_i | input | 1 | Serial clock, idles low, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| chan_o | output | 3 | Latched channel code |
| unipolar_o | output | 1 | Latched polarity (1 = unipolar) |
| single_o | output | 1 | Latched input configuration (1 = single-ended) |
| pmode_o | output | 2 | Latched power/clock mode |
| conv_req_o | output | 1 | One-cycle conversion request |

## Verification
The hardest state to reach is a select-low period that continues after a word has already been taken. To get there, the stimulus keeps select low, sends a second full word with different fields, and checks that the held outputs and the request count do not change. It then cycles select and confirms that the second word is now accepted. The main sweep covers all 128 words that follow the marker. Between zero and three leading zeros are placed before each word, so the start-bit search is exercised at every offset.

// File: rtl/ctl_byte_pkg.sv
package ctl_byte_pkg;
   localparam int WORD_W = 8;
   localparam int CHAN_W = 3;
   localparam int MODE_W = 2;
   localparam int CHAN_LSB = 4;
   localparam int UNI_BIT = 3;
   localparam int SGL_BIT = 2;

   typedef enum logic [1:0] {
      FR_HUNT  = 2'd0,
      FR_SHIFT = 2'd1,
      FR_HELD  = 2'd2
   } fr_state_e;

   typedef enum logic [MODE_W-1:0] {
      PM_FULL_OFF = 2'b00,
      PM_FAST_OFF = 2'b01,
      PM_INT_CLK  = 2'b10,
      PM_EXT_CLK  = 2'b11
   } pmode_e;
endpackage

// File: rtl/cbr_sync.sv
module cbr_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cbr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cbr_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/cbr_framer.sv
module cbr_framer
   import ctl_byte_pkg::*;
#(
   parameter int W = WORD_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel_s,
   input  logic         sclk_s,
   input  logic         sdi_s,
   output logic         word_vld_o,
   output logic [W-1:0] word_o
);
   localparam int CNT_W = $clog2(W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 2);

   if (W < 3) begin : g_bad_w
      $error("cbr_framer: W must be at least 3");
   end

   fr_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [W-1:0]     shreg;
   logic             sclk_d;
   logic             rise;

   assign rise   = sclk_s & ~sclk_d;
   assign word_o = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= FR_HUNT;
         cnt        <= '0;
         shreg      <= '0;
         sclk_d     <= 1'b0;
         word_vld_o <= 1'b0;
      end else begin
         sclk_d     <= sclk_s;
         word_vld_o <= 1'b0;
         if (sel_s) begin
            state <= FR_HUNT;
            cnt   <= '0;
         end else if (rise) begin
            unique case (state)
               FR_HUNT: if (sdi_s) begin
                  shreg <= {{(W-1){1'b0}}, 1'b1};
                  cnt   <= '0;
                  state <= FR_SHIFT;
               end
               FR_SHIFT: begin
                  shreg <= {shreg[W-2:0], sdi_s};
                  cnt   <= cnt + 1'b1;
                  if (cnt == LAST) begin
                     state      <= FR_HELD;
                     word_vld_o <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R5
   abort_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_s |=> !word_vld_o);
   // R2
   vld_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |-> word_o[W-1]);
   // R6
   held_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FR_HELD && !sel_s) |=> (state == FR_HELD && !word_vld_o));
endmodule

// File: rtl/cbr_decode.sv
module cbr_decode
   import ctl_byte_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_vld_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [CHAN_W-1:0] chan_o,
   output logic              unipolar_o,
   output logic              single_o,
   output logic [MODE_W-1:0] pmode_o,
   output logic              conv_req_o
);
   if (CHAN_LSB + CHAN_W != WORD_W - 1) begin : g_bad_layout
      $error("cbr_decode: channel field must sit below the start bit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_o     <= '0;
         unipolar_o <= 1'b1;
         single_o   <= 1'b1;
         pmode_o    <= PM_FULL_OFF;
         conv_req_o <= 1'b0;
      end else begin
         conv_req_o <= word_vld_i;
         if (word_vld_i) begin
            chan_o     <= word_i[CHAN_LSB +: CHAN_W];
            unipolar_o <= word_i[UNI_BIT];
            single_o   <= word_i[SGL_BIT];
            pmode_o    <= word_i[MODE_W-1:0];
         end
      end
   end

   // R4
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req_o |=> !conv_req_o);
   // R7
   fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_req_o |-> ($stable(chan_o) && $stable(unipolar_o)
                       && $stable(single_o) && $stable(pmode_o)));
endmodule

// File: rtl/ctl_byte_rx.sv
module ctl_byte_rx
   import ctl_byte_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n_i,
   input  logic              sclk_i,
   input  logic              sdi_i,
   output logic [CHAN_W-1:0] chan_o,
   output logic              unipolar_o,
   output logic              single_o,
   output logic [MODE_W-1:0] pmode_o,
   output logic              conv_req_o
);
   logic [2:0]        sync_v;
   logic              word_vld;
   logic [WORD_W-1:0] word;

   cbr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({sel_n_i, sclk_i, sdi_i}),
      .sync_o  (sync_v)
   );

   cbr_framer #(.W(WORD_W)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_s      (sync_v[2]),
      .sclk_s     (sync_v[1]),
      .sdi_s      (sync_v[0]),
      .word_vld_o (word_vld),
      .word_o     (word)
   );

   cbr_decode u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_vld_i (word_vld),
      .word_i     (word),
      .chan_o     (chan_o),
      .unipolar_o (unipolar_o),
      .single_o   (single_o),
      .pmode_o    (pmode_o),
      .conv_req_o (conv_req_o)
   );
endmodule

// File: tb/ctl_byte_rx_test.sv
module ctl_byte_rx_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdi = 1'b0;
   logic [2:0] chan;
   logic       uni, sgl, req;
   logic [1:0] pmode;

   int n_cmp = 0;
   int n_bad = 0;
   int pulses = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   ctl_byte_rx uut (
      .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(sdi),
      .chan_o(chan), .unipolar_o(uni), .single_o(sgl), .pmode_o(pmode),
      .conv_req_o(req)
   );

   always @(negedge clk) if (req) pulses++;

   task automatic check(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send_bit(input logic b);
      sdi = b;
      wait_clk(5);
      sclk = 1'b1;
      wait_clk(5);
      sclk = 1'b0;
   endtask

   task automatic send_word(input logic [7:0] w, input int zeros);
      for (int z = 0; z < zeros; z++) send_bit(1'b0);
      for (int i = 7; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic sel_low();
      sel_n = 1'b0;
      wait_clk(6);
   endtask

   task automatic sel_high();
      wait_clk(8);
      sel_n = 1'b1;
      wait_clk(8);
   endtask

   task automatic check_fields(input string tag, input logic [7:0] w);
      check({tag, " chan"}, int'(chan), int'((w >> 4) & 8'd7));
      check({tag, " uni"},  int'(uni),  int'((w >> 3) & 8'd1));
      check({tag, " sgl"},  int'(sgl),  int'((w >> 2) & 8'd1));
      check({tag, " pmode"}, int'(pmode), int'(w & 8'd3));
   endtask

   initial begin
      int base;
      logic [7:0] w;
      wait_clk(3);
      // R1 reset state
      check("R1 chan", int'(chan), 0);
      check("R1 uni", int'(uni), 1);
      check("R1 sgl", int'(sgl), 1);
      check("R1 pmode", int'(pmode), 0);
      check("R1 req", int'(req), 0);
      rst_n = 1'b1;
      wait_clk(4);

      // R2 R3 R4 sweep over all words with 0..3 leading zeros
      for (int k = 0; k < 128; k++) begin
         w = 8'h80 | 8'(k);
         base = pulses;
         sel_low();
         send_word(w, k % 4);
         wait_clk(12);
         check("R4 one pulse", pulses - base, 1);
         check_fields("R2 R3", w);
         sel_high();
      end

      // R8 only zero bits
      base = pulses;
      sel_low();
      for (int z = 0; z < 12; z++) send_bit(1'b0);
      sel_high();
      check("R8 no pulse", pulses - base, 0);
      check_fields("R8 hold", 8'hFF);

      // R5 abort after start + 3 bits
      base = pulses;
      sel_low();
      send_bit(1'b0);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
      sel_high();
      check("R5 no pulse", pulses - base, 0);
      check_fields("R5 hold", 8'hFF);
      sel_low();
      send_word(8'hA6, 2);
      wait_clk(12);
      check("R5 recover pulse", pulses - base, 1);
      check_fields("R5 recover", 8'hA6);
      sel_high();

      // R6 second word in same select period ignored
      base = pulses;
      sel_low();
      send_word(8'hC9, 1);
      wait_clk(12);
      send_word(8'hB6, 0);
      wait_clk(12);
      check("R6 single pulse", pulses - base, 1);
      check_fields("R6 hold", 8'hC9);
      sel_high();
      sel_low();
      send_word(8'hB6, 0);
      wait_clk(12);
      check("R6 next period pulse", pulses - base, 2);
      check_fields("R6 next", 8'hB6);
      sel_high();

      // R7 outputs stay put across idle time
      wait_clk(50);
      check_fields("R7 idle", 8'hB6);

      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule